// File: doc/BRIEF.md
# Debug Control Register

This block is the control register that a host debug link uses to steer an 8-bit CPU core. It holds four live bits: a debug-mode flag that halts instruction fetch, a breakpoint enable, an acknowledge enable, and a reset request that clears itself. The host writes the register through a simple strobe-and-data port and can read its current state at any time. The value it reads includes any bits that the hardware has set or cleared.

The CPU reports each decoded break instruction on a one-cycle strobe. When breakpoints are enabled, the break is taken: the block enters debug mode, halts the core, and can ask a serial transmitter to send an acknowledge byte to the host. When breakpoints are disabled, the block tells the core to treat the break as a no-op. A read-protect input locks debug mode once it is set, so only a power-on reset can clear it.

Setting the reset bit starts a fixed-length system reset. This reset does not disturb the register itself. The reset bit clears by itself when the sequence ends. This lets the host choose, with one write, between reset-then-halt and reset-then-run.

Top module: `dbg_ctl_reg`

## Requirements
- R1: After `rst_n` the register reads 0x00. Its layout is: bit 7 debug mode, bit 6 breakpoint enable, bit 5 acknowledge enable, bit 0 reset request. Bits 4..1 always read 0, and writes to those bits have no effect.
- R2: `halt` is high exactly while the debug-mode bit reads 1. A host write of 0 to bit 7 (with `rd_prot` low) drops `halt` on the clock edge that takes the write.
- R3: A `brk_strobe` while the breakpoint enable is 1 sets the debug-mode bit on that clock edge.
- R4: While the breakpoint enable is 0, `brk_nop` is high. A `brk_strobe` in that state leaves the debug-mode bit unchanged and raises no acknowledge request.
- R5: A taken break while the acknowledge enable is 1 raises `ack_req` on the next edge, with `ack_byte` = 0xFF. `ack_req` stays high until a cycle in which `tx_ready` is high, and then falls on the following edge.
- R6: While `rd_prot` is high, a host write cannot clear a set debug-mode bit. The other bits are still written.
- R7: A write with bit 0 = 1 makes `sys_rst` high for exactly RST_CYCLES (16) cycles, starting at the edge that takes the write. Bit 0 reads 1 for the same cycles and then returns to 0. The other register bits are kept across the sequence.
- R8: Writing 0x81 gives a system reset that ends with the core still halted (0x80). Writing 0x01 while in debug mode releases the halt and runs the system reset, ending at 0x00.
- R9: When a taken break and a host write arrive in the same cycle, the debug-mode bit becomes 1. The other bits take the written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current register value |
| rd_prot | input | 1 | Read-protect option; locks debug mode once set |
| brk_strobe | input | 1 | CPU decoded a break instruction |
| brk_nop | output | 1 | Break instruction must execute as a no-op |
| halt | output | 1 | Stop fetching new instructions |
| ack_req | output | 1 | Request to send the acknowledge byte |
| ack_byte | output | 8 | Byte to transmit (0xFF) |
| tx_ready | input | 1 | Transmitter accepts the request |
| sys_rst | output | 1 | System reset that excludes this register |

## Verification
The bench puts a break strobe and a host write in the same cycle. A design that lets the write win would come back out of debug mode and miss the breakpoint. It holds `tx_ready` low for several cycles after a taken break, to catch a request that drops after one cycle and is lost. It tries to clear debug mode under read protection, and it counts the `sys_rst` cycles exactly, so a design that is off by one or resets its own register shows up. It also writes the reserved bits and breaks with breakpoints disabled; a design that latched stray bits or halted on the no-op would read back the wrong value.

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg #(
  parameter int         RST_CYCLES = 16,
  parameter logic [7:0] ACK_CODE   = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       rd_prot,
  input  logic       brk_strobe,
  output logic       brk_nop,
  output logic       halt,
  output logic       ack_req,
  output logic [7:0] ack_byte,
  input  logic       tx_ready,
  output logic       sys_rst
);
  localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

  logic dbg_q, bpen_q, acken_q, rst_q, ack_q;
  logic [CW-1:0] cnt_q;
  logic taken;

  assign taken = brk_strobe & bpen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q   <= 1'b0;
      bpen_q  <= 1'b0;
      acken_q <= 1'b0;
      rst_q   <= 1'b0;
      ack_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (taken)
        dbg_q <= 1'b1;
      else if (wr_en && (wr_data[7] || !rd_prot))
        dbg_q <= wr_data[7];

      if (wr_en) begin
        bpen_q  <= wr_data[6];
        acken_q <= wr_data[5];
      end

      if (rst_q) begin
        if (cnt_q == LAST) rst_q <= 1'b0;
        else               cnt_q <= cnt_q + 1'b1;
      end else if (wr_en && wr_data[0]) begin
        rst_q <= 1'b1;
        cnt_q <= '0;
      end

      if (taken && acken_q) ack_q <= 1'b1;
      else if (tx_ready)    ack_q <= 1'b0;
    end
  end

  assign rd_data  = {dbg_q, bpen_q, acken_q, 4'b0000, rst_q};
  assign halt     = dbg_q;
  assign brk_nop  = ~bpen_q;
  assign ack_req  = ack_q;
  assign ack_byte = ACK_CODE;
  assign sys_rst  = rst_q;
endmodule

// File: rtl/dbg_ctl_reg_chk.sv
module dbg_ctl_reg_chk #(
  parameter int RST_CYCLES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_rst,
  input logic       rd_prot,
  input logic       brk_strobe,
  input logic       tx_ready,
  input logic [7:0] rd_data,
  input logic       halt,
  input logic       ack_req,
  input logic       sys_rst
);
  logic [31:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       hi_cnt <= '0;
    else if (sys_rst) hi_cnt <= hi_cnt + 1;
    else              hi_cnt <= '0;

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rd_data[4:1] == 4'b0000); // R1
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) halt && !wr_en |=> halt); // R2
  AST_BRK_SETS: assert property (@(posedge clk) disable iff (!rst_n) brk_strobe && rd_data[6] |=> rd_data[7]); // R3
  AST_NOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n) brk_strobe && !rd_data[6] && !wr_en |=> $stable(rd_data[7])); // R4
  AST_ACK_RAISE: assert property (@(posedge clk) disable iff (!rst_n) brk_strobe && rd_data[6] && rd_data[5] |=> ack_req); // R5
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ack_req && !tx_ready |=> ack_req); // R5
  AST_PROT_LOCK: assert property (@(posedge clk) disable iff (!rst_n) rd_prot && rd_data[7] |=> rd_data[7]); // R6
  AST_RST_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(sys_rst) |-> $past(wr_en && wr_rst)); // R7
  AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(sys_rst) |-> hi_cnt == RST_CYCLES); // R7
endmodule

bind dbg_ctl_reg dbg_ctl_reg_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_rst(wr_data[0]),
  .rd_prot(rd_prot), .brk_strobe(brk_strobe), .tx_ready(tx_ready),
  .rd_data(rd_data), .halt(halt), .ack_req(ack_req), .sys_rst(sys_rst)
);

// File: tb/dbg_ctl_reg_test.sv
module dbg_ctl_reg_test;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_prot = 0, brk_strobe = 0, tx_ready = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data, ack_byte;
  logic brk_nop, halt, ack_req, sys_rst;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  dbg_ctl_reg uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rd_prot(rd_prot), .brk_strobe(brk_strobe), .brk_nop(brk_nop), .halt(halt),
    .ack_req(ack_req), .ack_byte(ack_byte), .tx_ready(tx_ready), .sys_rst(sys_rst)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic brk();
    brk_strobe = 1;
    @(negedge clk);
    brk_strobe = 0;
  endtask

  task automatic t_reset_state();
    chk("R1 reset value", rd_data, 8'h00);
    chk("R2 halt after reset", {7'b0, halt}, 8'h00);
    chk("R4 nop after reset", {7'b0, brk_nop}, 8'h01);
  endtask

  task automatic t_reserved();
    wr(8'h1E);
    chk("R1 reserved write", rd_data, 8'h00);
    wr(8'h7E);
    chk("R1 mixed write", rd_data, 8'h60);
    wr(8'h00);
  endtask

  task automatic t_halt_release();
    wr(8'h80);
    chk("R2 halt set", {rd_data[7], 6'b0, halt}, 8'h81);
    wr(8'h00);
    chk("R2 halt released", {rd_data[7], 6'b0, halt}, 8'h00);
  endtask

  task automatic t_nop_break();
    wr(8'h20);
    chk("R4 nop flag", {7'b0, brk_nop}, 8'h01);
    brk();
    chk("R4 mode unchanged", rd_data, 8'h20);
    chk("R4 no halt", {7'b0, halt}, 8'h00);
    chk("R4 no ack", {7'b0, ack_req}, 8'h00);
    wr(8'h00);
  endtask

  task automatic t_break_ack();
    tx_ready = 0;
    wr(8'h60);
    chk("R4 nop clear", {7'b0, brk_nop}, 8'h00);
    brk();
    chk("R3 break sets mode", rd_data, 8'hE0);
    chk("R2 halt on break", {7'b0, halt}, 8'h01);
    chk("R5 ack raised", {7'b0, ack_req}, 8'h01);
    chk("R5 ack byte", ack_byte, 8'hFF);
    repeat (4) @(negedge clk);
    chk("R5 ack held", {7'b0, ack_req}, 8'h01);
    tx_ready = 1;
    @(negedge clk);
    chk("R5 ack dropped", {7'b0, ack_req}, 8'h00);
    tx_ready = 0;
    wr(8'h40);
    brk();
    chk("R5 no ack when disabled", {7'b0, ack_req}, 8'h00);
    chk("R3 mode set", rd_data, 8'hC0);
    wr(8'h00);
  endtask

  task automatic t_protect();
    wr(8'h80);
    rd_prot = 1;
    wr(8'h00);
    chk("R6 clear blocked", rd_data, 8'h80);
    wr(8'h40);
    chk("R6 other bits written", rd_data, 8'hC0);
    rd_prot = 0;
    wr(8'h00);
    chk("R6 clear after unlock", rd_data, 8'h00);
  endtask

  task automatic t_same_cycle();
    wr(8'h40);
    brk_strobe = 1;
    wr(8'h00);
    brk_strobe = 0;
    chk("R9 break beats write", rd_data, 8'h80);
    wr(8'h00);
  endtask

  task automatic t_sys_reset(input logic [7:0] pre, input logic [7:0] cmd,
                             input logic [7:0] during, input logic [7:0] after);
    int hi = 0;
    if (pre != 8'h00) wr(pre);
    wr(cmd);
    chk("R8 value during reset", rd_data, during);
    for (int i = 0; i < 40; i++) begin
      if (sys_rst) hi++;
      @(negedge clk);
    end
    chk("R7 reset length", 8'(hi), 8'd16);
    chk("R8 value after reset", rd_data, after);
    chk("R7 reset bit cleared", {7'b0, sys_rst}, 8'h00);
    wr(8'h00);
  endtask

  task automatic t_reset_keeps();
    wr(8'h61);
    chk("R7 reset bit reads 1", rd_data, 8'h61);
    repeat (20) @(negedge clk);
    chk("R7 register kept", rd_data, 8'h60);
    wr(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_reserved();
    t_halt_release();
    t_nop_break();
    t_break_ack();
    t_protect();
    t_same_cycle();
    t_sys_reset(8'h00, 8'h81, 8'h81, 8'h80);
    t_sys_reset(8'h80, 8'h01, 8'h01, 8'h00);
    t_reset_keeps();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule